// File: doc/BRIEF.md
# Fastlock Charge-Pump Gain Timer

This block decides which of two programmed 3-bit charge-pump current codes reaches the charge pump while a synthesizer retunes. A primary code is meant for steady state. A secondary, usually stronger code is meant for the settling period after a new divider word is written. Software sets a gain bit along with the divider word. The block then holds the secondary code either until software writes the bit back to 0 (manual mode) or for a programmed number of phase-detector cycles (timed mode).

In timed mode, a down-counter is loaded with 3 + 4 × code, where code is the 4-bit timeout field. The counter steps once per phase-detector strobe. When it runs out, the block pulses an auto-clear output for the register file, drops its own copy of the gain bit and restores the primary code. Power-down and the counter-reset request both stop a running timeout at once.

Top module: `fastlock_gain_timer`

## Requirements
- R1: After reset `cur_sel_o` equals `cur_pri_i`, `boost_o` is 0 and `gain_clr_o` is 0.
- R2: While `fl_en_i` is 0, `cur_sel_o` equals `cur_pri_i` whatever the gain bit holds. A gain bit written as 1 in that time still takes effect once `fl_en_i` becomes 1.
- R3: Manual mode (`fl_en_i`=1, `fl_timed_i`=0): after a write (`gain_wr_i`=1) with `gain_wd_i`=1, `cur_sel_o` equals `cur_sec_i` from the next cycle on and stays there for any number of strobes. A write of 0 restores `cur_pri_i`. `gain_clr_o` never pulses in this mode.
- R4: Timed mode (`fl_en_i`=1, `fl_timed_i`=1): after a write of 1, the secondary code is held for exactly 3 + 4 × `tmo_code_i` strobes of `pfd_tick_i`, where `tmo_code_i` is read as an unsigned binary number (code 0 gives 3, code 15 gives 63).
- R5: On the strobe that ends the timeout, `gain_clr_o` is high for that one clock only, and `cur_sel_o` returns to `cur_pri_i` in the following cycle.
- R6: Cycles without a strobe do not advance the timeout.
- R7: Writing 1 while a timeout runs, including on the final strobe, reloads the full period and suppresses that cycle's clear pulse.
- R8: Writing 0 while a timeout runs restores the primary code in the next cycle without a clear pulse.
- R9: While `pwr_down_i` is high, any running timeout is cancelled, the gain bit is dropped and gain writes are ignored. The primary code is selected from the next cycle on.
- R10: `cnt_rst_i` has the same abort effect as power-down.
- R11: Leaving timed mode while a timeout runs stops the timeout. The gain bit stays set, so the secondary code stays selected until a write of 0 and no clear pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fl_en_i | input | 1 | Fastlock enable |
| fl_timed_i | input | 1 | 0 selects manual mode, 1 selects timed mode |
| cur_pri_i | input | 3 | Primary (steady-state) current code |
| cur_sec_i | input | 3 | Secondary (settling) current code |
| tmo_code_i | input | 4 | Timeout code; period = 3 + 4 × code strobes |
| gain_wr_i | input | 1 | One-cycle strobe: divider word written |
| gain_wd_i | input | 1 | Gain bit value carried by that write |
| pfd_tick_i | input | 1 | One strobe per phase-detector cycle |
| pwr_down_i | input | 1 | Power-down; aborts the timeout |
| cnt_rst_i | input | 1 | Counter reset request; aborts the timeout |
| cur_sel_o | output | 3 | Active charge-pump current code |
| boost_o | output | 1 | High while the secondary code is selected |
| gain_clr_o | output | 1 | One-clock pulse that clears the stored gain bit |

## Verification
If the down-counter is loaded with a wrong value, or steps on a cycle without a strobe, the error shows up as a wrong number of strobes between the write and the return of `cur_sel_o` to the primary code. It becomes visible at the end of that period, at most 63 strobes after the write. If the gain flag is stuck or mis-prioritised, `cur_sel_o` is wrong in the cycle right after the offending write, abort or expiry. A clear pulse that is missing, doubled or stray is visible on `gain_clr_o` in the very cycle of the final strobe or write.

// File: rtl/fl_pkg.sv
package fl_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_STEP  = 2'd2,
    CMD_CLEAR = 2'd3
  } tmo_cmd_e;
endpackage

// File: rtl/fl_tmo_counter.sv
module fl_tmo_counter
  import fl_pkg::*;
#(
  parameter int TC_W     = 4,
  parameter int TMO_BASE = 3,
  parameter int TMO_STEP = 4,
  localparam int MAX_LEN = TMO_BASE + TMO_STEP * ((1 << TC_W) - 1),
  localparam int CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tmo_cmd_e        cmd_i,
  input  logic [TC_W-1:0] tc_i,
  output logic            busy_o,
  output logic            last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (cmd_i)
      CMD_LOAD: begin
        cnt_d  = CNT_W'(TMO_BASE + TMO_STEP * int'(tc_i));
        cnt_en = 1'b1;
      end
      CMD_STEP: begin
        if (cnt_q != '0) begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      CMD_CLEAR: begin
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CNT_W'(1));

  // R9 R10 R11
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_CLEAR) |=> !busy_o);

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_HOLD) |=> $stable(cnt_q));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_STEP && busy_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fl_gain_flag.sv
module fl_gain_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic abort_i,
  input  logic wr_i,
  input  logic wd_i,
  input  logic expire_i,
  output logic gain_o
);
  logic gain_q, gain_d;

  always_comb begin
    gain_d = gain_q;
    if (abort_i)       gain_d = 1'b0;
    else if (wr_i)     gain_d = wd_i;
    else if (expire_i) gain_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gain_q <= 1'b0;
    else        gain_q <= gain_d;
  end

  assign gain_o = gain_q;

  // R9 R10
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !gain_o);

  // R3
  write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !abort_i) |=> (gain_o == $past(wd_i)));
endmodule

// File: rtl/fl_cur_mux.sv
module fl_cur_mux #(
  parameter int CUR_W = 3
) (
  input  logic             use_sec_i,
  input  logic [CUR_W-1:0] pri_i,
  input  logic [CUR_W-1:0] sec_i,
  output logic [CUR_W-1:0] cur_o
);
  always_comb begin
    cur_o = use_sec_i ? sec_i : pri_i;
  end
endmodule

// File: rtl/fastlock_gain_timer.sv
module fastlock_gain_timer
  import fl_pkg::*;
#(
  parameter int CUR_W    = 3,
  parameter int TC_W     = 4,
  parameter int TMO_BASE = 3,
  parameter int TMO_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fl_en_i,
  input  logic             fl_timed_i,
  input  logic [CUR_W-1:0] cur_pri_i,
  input  logic [CUR_W-1:0] cur_sec_i,
  input  logic [TC_W-1:0]  tmo_code_i,
  input  logic             gain_wr_i,
  input  logic             gain_wd_i,
  input  logic             pfd_tick_i,
  input  logic             pwr_down_i,
  input  logic             cnt_rst_i,
  output logic [CUR_W-1:0] cur_sel_o,
  output logic             boost_o,
  output logic             gain_clr_o
);
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic     timed_on, abort, busy, last, gain, expire;
  tmo_cmd_e cmd;

  assign timed_on = fl_en_i & fl_timed_i;
  assign abort    = pwr_down_i | cnt_rst_i;
  assign expire   = timed_on & pfd_tick_i & last & ~abort & ~gain_wr_i;

  always_comb begin
    cmd = CMD_HOLD;
    if (abort || !timed_on)           cmd = CMD_CLEAR;
    else if (gain_wr_i && gain_wd_i)  cmd = CMD_LOAD;
    else if (gain_wr_i)               cmd = CMD_CLEAR;
    else if (pfd_tick_i)              cmd = CMD_STEP;
  end

  fl_tmo_counter #(
    .TC_W(TC_W), .TMO_BASE(TMO_BASE), .TMO_STEP(TMO_STEP)
  ) u_cnt (
    .clk(clk), .rst_n(srst_n), .cmd_i(cmd), .tc_i(tmo_code_i),
    .busy_o(busy), .last_o(last)
  );

  fl_gain_flag u_flag (
    .clk(clk), .rst_n(srst_n), .abort_i(abort), .wr_i(gain_wr_i),
    .wd_i(gain_wd_i), .expire_i(expire), .gain_o(gain)
  );

  assign boost_o    = fl_en_i & gain;
  assign gain_clr_o = expire;

  fl_cur_mux #(.CUR_W(CUR_W)) u_mux (
    .use_sec_i(boost_o), .pri_i(cur_pri_i), .sec_i(cur_sec_i), .cur_o(cur_sel_o)
  );

  // R5
  clr_one_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    gain_clr_o |=> !gain_clr_o);

  // R5
  clr_then_primary_chk: assert property (@(posedge clk) disable iff (!srst_n)
    gain_clr_o |=> !boost_o);

  // R6
  clr_on_tick_chk: assert property (@(posedge clk) disable iff (!srst_n)
    gain_clr_o |-> (pfd_tick_i && busy));

  // R3
  manual_no_clr_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !fl_timed_i |-> !gain_clr_o);

  // R9 R10
  abort_primary_chk: assert property (@(posedge clk) disable iff (!srst_n)
    abort |=> !boost_o);
endmodule

// File: tb/fastlock_gain_timer_test.sv
`timescale 1ns/1ps
module fastlock_gain_timer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fl_en, fl_timed, gwr, gwd, tick, pd, crst;
  logic [2:0] pri, sec, cur;
  logic [3:0] tc;
  logic       boost, clr;
  int         checks = 0, fails = 0;

  localparam logic [2:0] PRI = 3'b010;
  localparam logic [2:0] SEC = 3'b101;

  // timeout code, expected strobe count, insert idle gaps
  localparam int NVEC = 5;
  localparam int VEC [NVEC][3] = '{
    '{0, 3, 0}, '{1, 7, 1}, '{5, 23, 0}, '{7, 31, 1}, '{15, 63, 0}
  };

  always #4 clk = ~clk;

  fastlock_gain_timer uut (
    .clk(clk), .rst_n(rst_n), .fl_en_i(fl_en), .fl_timed_i(fl_timed),
    .cur_pri_i(pri), .cur_sec_i(sec), .tmo_code_i(tc), .gain_wr_i(gwr),
    .gain_wd_i(gwd), .pfd_tick_i(tick), .pwr_down_i(pd), .cnt_rst_i(crst),
    .cur_sel_o(cur), .boost_o(boost), .gain_clr_o(clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one cycle from a negedge: drive, sample pulse, wait for next negedge
  task automatic cyc(input logic t, input logic w, input logic d, output logic c);
    tick = t; gwr = w; gwd = d;
    #1 c = clr;
    @(negedge clk);
    tick = 0; gwr = 0; gwd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic c;
    int   n, pulses;
    rst_n = 0; fl_en = 1; fl_timed = 1; gwr = 0; gwd = 0; tick = 0;
    pd = 0; crst = 0; pri = PRI; sec = SEC; tc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1
    #1;
    chk("R1 cur", int'(cur), int'(PRI));
    chk("R1 boost", int'(boost), 0);
    chk("R1 clr", int'(clr), 0);
    @(negedge clk);

    // R4 R5 R6: table walk
    for (int v = 0; v < NVEC; v++) begin
      tc = 4'(VEC[v][0]);
      cyc(0, 1, 1, c);
      chk("R4 secondary after write", int'(cur), int'(SEC));
      n = 0; pulses = 0;
      while (cur == SEC && n < 100) begin
        cyc(1, 0, 0, c);
        n++;
        if (c) pulses++;
        if (VEC[v][2] != 0 && cur == SEC) begin
          cyc(0, 0, 0, c);
          if (c) pulses++;
        end
      end
      chk("R4 strobe count", n, VEC[v][1]);
      chk("R5 one clear pulse", pulses, 1);
      chk("R5 primary after clear", int'(cur), int'(PRI));
    end

    // R7: rewrite on final strobe reloads, no pulse
    tc = 0;
    cyc(0, 1, 1, c);
    cyc(1, 0, 0, c); cyc(1, 0, 0, c);
    cyc(1, 1, 1, c);
    chk("R7 no pulse on reload", int'(c), 0);
    chk("R7 still secondary", int'(cur), int'(SEC));
    cyc(1, 0, 0, c); cyc(1, 0, 0, c);
    chk("R7 still secondary after 2", int'(cur), int'(SEC));
    cyc(1, 0, 0, c);
    chk("R7 pulse at full period", int'(c), 1);
    chk("R7 primary", int'(cur), int'(PRI));

    // R8: write 0 mid-timeout
    tc = 3;
    cyc(0, 1, 1, c);
    cyc(1, 0, 0, c);
    cyc(0, 1, 0, c);
    chk("R8 no pulse", int'(c), 0);
    chk("R8 primary", int'(cur), int'(PRI));
    pulses = 0;
    for (int k = 0; k < 20; k++) begin cyc(1, 0, 0, c); if (c) pulses++; end
    chk("R8 no later pulse", pulses, 0);

    // R9: power-down aborts, writes ignored
    cyc(0, 1, 1, c);
    cyc(1, 0, 0, c);
    pd = 1;
    cyc(0, 0, 0, c);
    chk("R9 primary in power-down", int'(cur), int'(PRI));
    cyc(0, 1, 1, c);
    chk("R9 write ignored", int'(cur), int'(PRI));
    pd = 0;
    pulses = 0;
    for (int k = 0; k < 10; k++) begin cyc(1, 0, 0, c); if (c) pulses++; end
    chk("R9 no pulse after abort", pulses, 0);
    chk("R9 stays primary", int'(cur), int'(PRI));

    // R10: counter reset aborts
    cyc(0, 1, 1, c);
    crst = 1;
    cyc(1, 0, 0, c);
    crst = 0;
    chk("R10 primary", int'(cur), int'(PRI));

    // R11: leave timed mode mid-run
    tc = 0;
    cyc(0, 1, 1, c);
    cyc(1, 0, 0, c);
    fl_timed = 0;
    pulses = 0;
    for (int k = 0; k < 8; k++) begin cyc(1, 0, 0, c); if (c) pulses++; end
    chk("R11 held secondary", int'(cur), int'(SEC));
    chk("R11 no pulse", pulses, 0);

    // R3: manual mode
    cyc(0, 1, 0, c);
    chk("R3 write 0 primary", int'(cur), int'(PRI));
    cyc(0, 1, 1, c);
    chk("R3 write 1 secondary", int'(cur), int'(SEC));
    pulses = 0;
    for (int k = 0; k < 70; k++) begin cyc(1, 0, 0, c); if (c) pulses++; end
    chk("R3 no timeout", int'(cur), int'(SEC));
    chk("R3 no pulse", pulses, 0);
    cyc(0, 1, 0, c);
    chk("R3 back to primary", int'(cur), int'(PRI));

    // R2: disabled uses primary; stored bit applies on enable
    fl_en = 0;
    cyc(0, 1, 1, c);
    chk("R2 disabled primary", int'(cur), int'(PRI));
    chk("R2 boost low", int'(boost), 0);
    fl_en = 1;
    #1 chk("R2 stored bit applies", int'(cur), int'(SEC));
    @(negedge clk);
    cyc(0, 1, 0, c);

    summary();
  end
endmodule